// File: doc/BRIEF.md
# PCI Master Read Command and Burst Selector

This block sits inside a bus-master DMA engine and, for every read bus ownership, picks the 4-bit PCI command code and the burst length that the data mover will use. It looks at four things: the configured cache line size, a programmed burst size, two mode enables (multi-line read and single-line read), and a per-transfer flag that tells it whether the cache-line alignment conditions hold.

The block keeps the normal operating burst size, which is the cache line size. When a multi-line read is chosen, it replaces that length with the programmed burst size for the duration of the transfer. When the transfer-done strobe arrives, it returns to the normal size. Multi-line read wins over single-line read when both are enabled. A programmed burst that is shorter than one cache line causes a fall back to a plain memory read.

The choice is made when a start strobe arrives while the block is idle. The command and length are then frozen until the done strobe.

Top module: `rdcmd_burst_sel`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` is 0 and `cmd_o` is 4'b0110 (Memory Read).
- R2: While idle, `burst_o` equals the value that was on `line_sz_i` on the previous clock edge. This is the normal operating burst size.
- R3: A start while idle, with `mult_en_i`=1, `cond_ok_i`=1 and `burst_cfg_i` >= `line_sz_i`, gives `cmd_o`=4'b1100 and `burst_o`=`burst_cfg_i` from the next cycle. This holds whatever the value of `line_en_i`.
- R4: A start while idle, with `mult_en_i`=0, `line_en_i`=1 and `cond_ok_i`=1, gives `cmd_o`=4'b1110 and `burst_o` equal to one cache line (the normal size).
- R5: A start while idle with `cond_ok_i`=0, or with both enables 0, gives `cmd_o`=4'b0110 and `burst_o` equal to the normal size.
- R6: A start while idle, with `mult_en_i`=1, `cond_ok_i`=1 and `burst_cfg_i` < `line_sz_i`, gives `cmd_o`=4'b0110 and the normal size. This holds even when `line_en_i`=1.
- R7: While `busy_o`=1, `cmd_o` and `burst_o` hold their values. A further `start_i` and changes on the configuration inputs have no effect until done.
- R8: A `done_i` pulse while busy clears `busy_o` on the next edge, and `burst_o` then returns to the normal size.
- R9: `cmd_o` is only ever 0110, 1100 or 1110. It never shows 0000, 0001, 1101 or a reserved code.
- R10: A `done_i` pulse while idle has no effect on `busy_o`, `cmd_o` or `burst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sz_i | input | LEN_W | Cache line size in dwords |
| burst_cfg_i | input | LEN_W | Programmed multi-line burst size in dwords |
| mult_en_i | input | 1 | Multi-line read mode enable |
| line_en_i | input | 1 | Single-line read mode enable |
| cond_ok_i | input | 1 | Cache-line conditions met for this transfer |
| start_i | input | 1 | Start of a read bus ownership |
| done_i | input | 1 | Transfer-done strobe |
| busy_o | output | 1 | A transfer is in progress |
| cmd_o | output | 4 | Bus command code for the transfer |
| burst_o | output | LEN_W | Burst length in effect |

## Verification
On every cycle, the assertions check four things: that the command is one of the three legal read codes, that command and length stay frozen during a transfer, that the idle length tracks the cache line size, and that done restores the normal size. They also check the multi-line choice, with its priority, right after a start. Only the bench's sweeps can show the full mapping from every combination of enables, condition flag, line size and burst setting to command and length. That includes the single-line case, the fall back on a short burst setting, and the inputs that are ignored while busy or idle.

// File: rtl/rdcmd_pkg.sv
package rdcmd_pkg;
  typedef enum logic [3:0] {
    CMD_MEM_RD      = 4'b0110,
    CMD_MEM_RD_MULT = 4'b1100,
    CMD_MEM_RD_LINE = 4'b1110
  } rd_cmd_e;
endpackage

// File: rtl/rdcmd_decide.sv
module rdcmd_decide
  import rdcmd_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [LEN_W-1:0] norm_len_i,
  input  logic [LEN_W-1:0] burst_cfg_i,
  input  logic             mult_en_i,
  input  logic             line_en_i,
  input  logic             cond_ok_i,
  output rd_cmd_e          cmd_o,
  output logic [LEN_W-1:0] len_o
);
  logic mult_fits;

  always_comb begin
    mult_fits = (burst_cfg_i >= norm_len_i);
    cmd_o     = CMD_MEM_RD;
    len_o     = norm_len_i;
    if (cond_ok_i && mult_en_i) begin
      // multi-line wins over single-line; a short setting drops to plain read
      if (mult_fits) begin
        cmd_o = CMD_MEM_RD_MULT;
        len_o = burst_cfg_i;
      end
    end else if (cond_ok_i && line_en_i) begin
      cmd_o = CMD_MEM_RD_LINE;
    end
  end
endmodule

// File: rtl/rdcmd_hold.sv
module rdcmd_hold
  import rdcmd_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] line_sz_i,
  input  logic             start_i,
  input  logic             done_i,
  input  rd_cmd_e          sel_cmd_i,
  input  logic [LEN_W-1:0] sel_len_i,
  output logic [LEN_W-1:0] norm_len_o,
  output logic             busy_o,
  output rd_cmd_e          cmd_o,
  output logic [LEN_W-1:0] len_o
);
  logic             busy_q, busy_d;
  rd_cmd_e          cmd_q, cmd_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] norm_q, norm_d;
  logic             take, release_x, norm_en;

  always_comb begin
    take      = start_i && !busy_q;
    release_x = done_i && busy_q;
    norm_en   = !busy_q;
    busy_d    = busy_q;
    cmd_d     = cmd_q;
    len_d     = len_q;
    norm_d    = norm_en ? line_sz_i : norm_q;
    if (take) begin
      busy_d = 1'b1;
      cmd_d  = sel_cmd_i;
      len_d  = sel_len_i;
    end else if (release_x) begin
      busy_d = 1'b0;
      cmd_d  = CMD_MEM_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= CMD_MEM_RD;
      len_q  <= '0;
      norm_q <= '0;
    end else begin
      busy_q <= busy_d;
      cmd_q  <= cmd_d;
      len_q  <= len_d;
      norm_q <= norm_d;
    end
  end

  assign norm_len_o = norm_q;
  assign busy_o     = busy_q;
  assign cmd_o      = cmd_q;
  assign len_o      = busy_q ? len_q : norm_q;

  // R7: frozen during a transfer
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> (busy_q && $stable(cmd_q) && $stable(len_o)));
  // R8: done releases and restores the normal length
  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i) |=> (!busy_q && len_o == $past(norm_q)));
  // R10: done while idle does not start anything
  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> (!busy_q && cmd_q == CMD_MEM_RD));
endmodule

// File: rtl/rdcmd_burst_sel.sv
module rdcmd_burst_sel
  import rdcmd_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] line_sz_i,
  input  logic [LEN_W-1:0] burst_cfg_i,
  input  logic             mult_en_i,
  input  logic             line_en_i,
  input  logic             cond_ok_i,
  input  logic             start_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic [3:0]       cmd_o,
  output logic [LEN_W-1:0] burst_o
);
  logic [LEN_W-1:0] norm_len;
  rd_cmd_e          sel_cmd;
  logic [LEN_W-1:0] sel_len;
  rd_cmd_e          cmd_r;

  rdcmd_decide #(.LEN_W(LEN_W)) u_decide (
    .norm_len_i  (norm_len),
    .burst_cfg_i (burst_cfg_i),
    .mult_en_i   (mult_en_i),
    .line_en_i   (line_en_i),
    .cond_ok_i   (cond_ok_i),
    .cmd_o       (sel_cmd),
    .len_o       (sel_len)
  );

  rdcmd_hold #(.LEN_W(LEN_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_sz_i  (line_sz_i),
    .start_i    (start_i),
    .done_i     (done_i),
    .sel_cmd_i  (sel_cmd),
    .sel_len_i  (sel_len),
    .norm_len_o (norm_len),
    .busy_o     (busy_o),
    .cmd_o      (cmd_r),
    .len_o      (burst_o)
  );

  assign cmd_o = cmd_r;

  // R9: only legal read codes ever leave the block
  p_legal_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'b0110 || cmd_o == 4'b1100 || cmd_o == 4'b1110));
  // R3: multi-line read chosen with priority when the setting covers a line
  p_mult_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && mult_en_i && cond_ok_i && burst_cfg_i >= norm_len)
    |=> (cmd_o == 4'b1100 && burst_o == $past(burst_cfg_i)));
  // R2: idle length follows the cache line size
  p_idle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> (burst_o == $past(line_sz_i)));
endmodule

// File: tb/sim_rdcmd_burst_sel.sv
module sim_rdcmd_burst_sel;
  localparam int LEN_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LEN_W-1:0] line_sz, burst_cfg;
  logic             mult_en, line_en, cond_ok, start, done;
  logic             busy;
  logic [3:0]       cmd;
  logic [LEN_W-1:0] burst;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdcmd_burst_sel #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .line_sz_i(line_sz), .burst_cfg_i(burst_cfg),
    .mult_en_i(mult_en), .line_en_i(line_en), .cond_ok_i(cond_ok),
    .start_i(start), .done_i(done), .busy_o(busy), .cmd_o(cmd), .burst_o(burst)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic expect_sel(input int ls, input int bc, input bit m, input bit l,
                            input bit ok, output int ecmd, output int elen,
                            output string req);
    ecmd = 6; elen = ls; req = "R5";
    if (ok && m) begin
      if (bc >= ls) begin ecmd = 12; elen = bc; req = "R3"; end
      else req = "R6";
    end else if (ok && l) begin
      ecmd = 14; req = "R4";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ecmd, elen;
    string req;
    rst_n = 1'b0; line_sz = 5'd4; burst_cfg = 5'd16;
    mult_en = 0; line_en = 0; cond_ok = 0; start = 0; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 cmd in reset", cmd, 6);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 cmd after reset", cmd, 6);
    chk("R2 idle length", burst, 4);

    // R10: done while idle
    done = 1;
    @(negedge clk);
    done = 0;
    chk("R10 busy", busy, 0);
    chk("R10 cmd", cmd, 6);
    chk("R10 length", burst, 4);

    for (int ls = 1; ls <= 8; ls++) begin
      for (int bc = 1; bc <= 16; bc++) begin
        for (int mode = 0; mode < 8; mode++) begin
          line_sz = LEN_W'(ls);
          @(negedge clk);
          chk("R2 idle length", burst, ls);
          mult_en = mode[0]; line_en = mode[1]; cond_ok = mode[2];
          burst_cfg = LEN_W'(bc);
          start = 1;
          @(negedge clk);
          start = 0;
          expect_sel(ls, bc, mode[0], mode[1], mode[2], ecmd, elen, req);
          chk({req, " busy"}, busy, 1);
          chk({req, " cmd"}, cmd, ecmd);
          chk({req, " length"}, burst, elen);
          // R7: disturb everything but the line size while busy
          mult_en = ~mode[0]; line_en = ~mode[1]; cond_ok = ~mode[2];
          burst_cfg = ~LEN_W'(bc);
          start = 1;
          @(negedge clk);
          start = 0;
          chk("R7 cmd held", cmd, ecmd);
          chk("R7 length held", burst, elen);
          done = 1;
          @(negedge clk);
          done = 0;
          chk("R8 busy cleared", busy, 0);
          chk("R8 length restored", burst, ls);
          chk("R9 idle code", cmd, 6);
        end
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule